// File: doc/BRIEF.md
# Reference Clock Source Selector

This block picks one of two free-running clocks, an on-chip RC oscillator or the system oscillator, to drive the reference input of a downstream PLL. Software programs it through a small word-addressed register port that runs on a separate bus clock. A source code written to the selection register is only staged. It moves to the clock path when software takes a separate arm bit from 0 to 1. Writing 1 to the arm bit while it is already 1 does nothing, so every switch needs a write of 0 followed by a write of 1.

The switch is break-before-make. The stage that owns the current source drops its enable on that clock's falling edge. Only after that drop has passed through the other domain's synchronizer does the new source raise its enable, also on a falling edge. The output therefore never carries a runt pulse. Both clocks must be running when a switch is committed. A status output, synchronized back to the bus clock, reports which source is actually driving the output once the hand-off has finished.

Top module: `refclk_sel`

## Requirements
- R1: After reset the selection register reads 0, the arm register reads 0, `src_o` is 0, and `ref_clk_o` follows `rc_clk_i`.
- R2: Committed code 0 makes `ref_clk_o` follow `rc_clk_i` and sets `src_o` to 0. Committed code 1 makes it follow `sys_clk_i` and sets `src_o` to 1.
- R3: A write to the selection register (address 0, bits [1:0]) changes neither `ref_clk_o` nor `src_o`.
- R4: A write that takes the arm register (address 1, bit 0) from 0 to 1 commits the staged code. When the code is valid, the new source drives the output within 1000 ns.
- R5: Writing 1 to the arm register while it already holds 1 commits nothing.
- R6: Committing code 2 or 3 leaves the previously committed valid source driving the output.
- R7: Register bits above the selection field (bits [31:2] at address 0) and above the arm bit (bits [31:1] at address 1) read as 0 and ignore writes. Any other address reads 0.
- R8: At most one source is enabled at any time. `ref_clk_o` never shows a high or low phase shorter than half a period of the faster source.
- R9: `src_o` changes only once the hand-off has completed, and it only ever holds code 0 or 1.
- R10: A read of the selection register returns the last written code, including while no commit has happened yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Word address (0 selection, 1 arm) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| rc_clk_i | input | 1 | RC oscillator clock |
| sys_clk_i | input | 1 | System oscillator clock |
| ref_clk_o | output | 1 | Glitch-free selected reference clock |
| src_o | output | 2 | Code of the source currently driving `ref_clk_o` |

## Verification
Each of the three kinds of internal state shows up at the ports in its own way. A wrong staged or committed code shows up in one of two ways. Either `ref_clk_o` runs at the wrong rate, which a 2 µs edge count catches, or `src_o` disagrees with the expected source within 1000 ns of the commit. A broken 0-to-1 detector shows up as a switch after a repeated arm write, or as no switch after a proper one. A broken gate chain shows up as a short phase on `ref_clk_o`, which the minimum phase-width monitor catches at the next switch.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned NUM_SRC = 2;

  typedef logic [SEL_W-1:0] sel_t;

  localparam sel_t SRC_RC  = 2'd0;
  localparam sel_t SRC_SYS = 2'd1;

  function automatic logic sel_valid(sel_t s);
    return int'(s) < int'(NUM_SRC);
  endfunction
endpackage

// File: rtl/refclk_sync.sv
module refclk_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {STAGES{RST_VAL}};
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/refclk_regs.sv
module refclk_regs
  import refclk_pkg::*;
#(
  parameter int unsigned         DATA_W   = 32,
  parameter int unsigned         ADDR_W   = 4,
  parameter logic [ADDR_W-1:0]   SEL_ADDR = '0,
  parameter logic [ADDR_W-1:0]   UPD_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output sel_t              sel_q_o,
  output logic              upd_q_o,
  output sel_t              target_o
);
  sel_t sel_q, target_q;
  logic upd_q;
  logic wr_sel, wr_upd, commit;
  logic unused_wdata;

  assign wr_sel = we_i && (addr_i == SEL_ADDR);
  assign wr_upd = we_i && (addr_i == UPD_ADDR);
  // only a 0->1 move of the arm bit commits
  assign commit = wr_upd && wdata_i[0] && !upd_q;
  assign unused_wdata = ^wdata_i[DATA_W-1:SEL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= SRC_RC;
      upd_q    <= 1'b0;
      target_q <= SRC_RC;
    end else begin
      if (wr_sel) sel_q <= wdata_i[SEL_W-1:0];
      if (wr_upd) upd_q <= wdata_i[0];
      if (commit && sel_valid(sel_q)) target_q <= sel_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == SEL_ADDR)      rdata_o[SEL_W-1:0] = sel_q;
    else if (addr_i == UPD_ADDR) rdata_o[0]         = upd_q;
  end

  assign sel_q_o  = sel_q;
  assign upd_q_o  = upd_q;
  assign target_o = target_q;
endmodule

// File: rtl/refclk_gate.sv
module refclk_gate
  import refclk_pkg::*;
#(
  parameter int unsigned IDX         = 0,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        RST_ON      = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  sel_t target_i,
  input  logic others_on_i,
  output logic en_o
);
  logic req, req_s, en_q;

  // request only once every other source has released the output
  assign req = (target_i == sel_t'(IDX)) && !others_on_i;

  refclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_ON)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req),
    .q_o   (req_s)
  );

  // enable moves while this clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= RST_ON;
    else         en_q <= req_s;
  end

  assign en_o = en_q;
endmodule

// File: rtl/refclk_sel.sv
module refclk_sel
  import refclk_pkg::*;
#(
  parameter int unsigned       DATA_W      = 32,
  parameter int unsigned       ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] SEL_ADDR    = '0,
  parameter logic [ADDR_W-1:0] UPD_ADDR    = 1,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              rc_clk_i,
  input  logic              sys_clk_i,
  output logic              ref_clk_o,
  output logic [SEL_W-1:0]  src_o
);
  sel_t                 sel_q, target_q, src_d, src_q;
  logic                 upd_q;
  logic [NUM_SRC-1:0]   clk_vec, gate_en, en_s;

  assign clk_vec = {sys_clk_i, rc_clk_i};

  refclk_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .UPD_ADDR(UPD_ADDR)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .sel_q_o (sel_q),
    .upd_q_o (upd_q),
    .target_o(target_q)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [NUM_SRC-1:0] SELF = NUM_SRC'(1) << g;
    logic others_on;
    assign others_on = |(gate_en & ~SELF);

    refclk_gate #(
      .IDX(g), .SYNC_STAGES(SYNC_STAGES), .RST_ON(g == 0)
    ) u_gate (
      .clk_i      (clk_vec[g]),
      .rst_ni     (rst_ni),
      .target_i   (target_q),
      .others_on_i(others_on),
      .en_o       (gate_en[g])
    );

    refclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(g == 0)) u_stat_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (gate_en[g]),
      .q_o   (en_s[g])
    );
  end

  assign ref_clk_o = |(clk_vec & gate_en);

  always_comb begin
    src_d = src_q;
    if ($onehot(en_s)) begin
      for (int i = 0; i < int'(NUM_SRC); i++) begin
        if (en_s[i]) src_d = sel_t'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= SRC_RC;
    else         src_q <= src_d;
  end

  assign src_o = src_q;
endmodule

// File: rtl/refclk_sel_chk.sv
module refclk_sel_chk
  import refclk_pkg::*;
#(
  parameter int unsigned       DATA_W   = 32,
  parameter int unsigned       ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] SEL_ADDR = '0,
  parameter logic [ADDR_W-1:0] UPD_ADDR = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic [SEL_W-1:0]   src_o,
  input sel_t               target_q,
  input sel_t               sel_q,
  input logic               upd_q,
  input logic [NUM_SRC-1:0] gate_en
);
  // R3
  sel_write_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == SEL_ADDR) |=> $stable(target_q));

  // R4
  arm_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == UPD_ADDR && reg_wdata_i[0] && !upd_q && sel_q < 2'd2)
    |=> target_q == $past(sel_q));

  // R5
  rearm_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == UPD_ADDR && upd_q) |=> $stable(target_q));

  // R6
  reserved_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == UPD_ADDR && sel_q >= 2'd2) |=> $stable(target_q));

  // R7
  sel_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DATA_W-1:SEL_W] == '0);

  // R7
  arm_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == UPD_ADDR) |-> reg_rdata_o[DATA_W-1:1] == '0);

  // R8
  one_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gate_en));

  // R9
  src_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_o < 2'd2);
endmodule

bind refclk_sel refclk_sel_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .UPD_ADDR(UPD_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .src_o      (src_o),
  .target_q   (target_q),
  .sel_q      (sel_q),
  .upd_q      (upd_q),
  .gate_en    (gate_en)
);

// File: tb/refclk_sel_bench.sv
`timescale 1ns/1ps
module refclk_sel_bench;
  localparam logic [3:0] A_SEL = 4'd0;
  localparam logic [3:0] A_UPD = 4'd1;

  logic        clk_i = 0, rst_ni = 0, rc_clk_i = 0, sys_clk_i = 0;
  logic        reg_we_i = 0;
  logic [3:0]  reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0;
  logic [31:0] reg_rdata_o;
  logic        ref_clk_o;
  logic [1:0]  src_o;

  int total = 0, bad = 0, ecnt = 0, short_cnt = 0;
  bit mon_on = 0;
  realtime last_edge = 0;

  always #10 clk_i = ~clk_i;
  always #7  rc_clk_i = ~rc_clk_i;
  always #17 sys_clk_i = ~sys_clk_i;

  refclk_sel u_refclk_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .rc_clk_i(rc_clk_i),
    .sys_clk_i(sys_clk_i), .ref_clk_o(ref_clk_o), .src_o(src_o)
  );

  always @(posedge ref_clk_o) ecnt++;

  // R8 phase-width monitor
  always @(ref_clk_o) begin
    if (mon_on && ($realtime - last_edge) < 6.9) short_cnt++;
    last_edge = $realtime;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #2 d = reg_rdata_o;
  endtask

  task automatic commit();
    wr(A_UPD, 0);
    wr(A_UPD, 1);
    #1000;
  endtask

  // edge count over 2 us: rc -> 142..143, sys -> 58..59
  task automatic chk_rate(string tag, int src);
    int c0, n, lo, hi;
    c0 = ecnt;
    #2000;
    n = ecnt - c0;
    lo = (src == 0) ? 140 : 56;
    hi = (src == 0) ? 145 : 61;
    total++;
    if (n < lo || n > hi) begin
      bad++;
      $display("FAIL %s edges act=%0d exp=%0d..%0d", tag, n, lo, hi);
    end
  endtask

  initial begin
    #5_000_000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cur;
    #55 rst_ni = 1;
    mon_on = 1;
    // R1 reset state
    rd(A_SEL, d); chk("R1 sel", d, 0);
    rd(A_UPD, d); chk("R1 arm", d, 0);
    chk("R1 src", 32'(src_o), 0);
    chk_rate("R1 rate", 0);

    // R10 / R3 staged write has no effect
    wr(A_SEL, 1);
    rd(A_SEL, d); chk("R10 pending readback", d, 1);
    #1000;
    chk("R3 src", 32'(src_o), 0);
    chk_rate("R3 rate", 0);

    // sweep: every start source x every code
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        wr(A_SEL, 32'(s)); commit();
        chk("R2 start src", 32'(src_o), 32'(s));
        cur = s;
        wr(A_SEL, 32'(c));
        rd(A_SEL, d); chk("R10 readback", d, 32'(c));
        #600;
        chk("R3 src hold", 32'(src_o), 32'(s));
        commit();
        if (c < 2) cur = c;
        chk((c < 2) ? "R4 src" : "R6 src", 32'(src_o), 32'(cur));
        chk_rate((c < 2) ? "R2 rate" : "R6 rate", cur);
        // R5 re-arm while armed
        wr(A_SEL, 32'(1 - cur));
        wr(A_UPD, 1);
        #1000;
        chk("R5 src", 32'(src_o), 32'(cur));
        chk_rate("R5 rate", cur);
      end
    end

    // R7 reserved bits and addresses
    wr(A_SEL, 32'hFFFF_FFFD);
    rd(A_SEL, d); chk("R7 sel upper", d, 1);
    wr(A_UPD, 32'hFFFF_FFFE);
    rd(A_UPD, d); chk("R7 arm upper", d, 0);
    wr(A_UPD, 32'hFFFF_FFFF);
    rd(A_UPD, d); chk("R7 arm bit", d, 1);
    rd(4'd2, d);  chk("R7 unmapped", d, 0);
    rd(4'd15, d); chk("R7 unmapped top", d, 0);
    #1000;
    chk("R4 commit via full word", 32'(src_o), 1);

    // R8 no short phase across all switches
    chk("R8 short phases", 32'(short_cnt), 0);
    // R9 status settles on committed source
    chk("R9 final src", 32'(src_o), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule